// File: doc/BRIEF.md
# Quad-Lane Serial Peripheral Master

This block is a register-programmed serial master that moves one word per frame over one, two or four data lanes. Software sets the lane mode, the transfer direction, the number of serial clocks in a frame and a clock divider. A write to the transmit register starts the next frame. At the end of each frame the captured word goes to a receive register and a status flag is raised. A software-owned bit drives the slave-select line, and an interrupt line reports whichever enabled status flags are set.

In single-lane mode the frame is full duplex: one lane sends and a second lane receives. In dual or quad mode the direction bit selects the transfer type. In a transmit transfer the lanes are driven. In a receive transfer every lane is released and the written word acts only as a trigger for the clock. When the next word is already waiting at the end of a frame, the next frame follows with no pause in the serial clock. Otherwise the clock stops low until the next write.

Top module: `qspi_master`

## Requirements
- R1: After reset the flag register reads 1 (transmit-empty set, receive-full and overrun clear), `sclk` is 0, `ss_n` is 1, `dq_oe` is 0 and `irq` is 0.
- R2: The register map is: control at address 0 (bits [1:0] lane mode, bit 2 direction, bit 3 select, bits [7:4] length), divider at 1 (bits [7:0]), transmit at 2, receive at 3, flags at 4, interrupt enables at 5. Mode 0 is single lane, mode 1 is dual lane and mode 2 is quad lane. A frame has length+1 serial clocks.
- R3: In single-lane mode the word goes out most significant bit first on `dq_out[0]`, with `dq_oe` equal to 0001. On each rising edge the block samples `dq_in[1]`, in the same frame.
- R4: In dual or quad mode with direction 1 (receive), `dq_oe` stays 0 for the whole frame. Each clock shifts in 2 or 4 bits from `dq_in[1:0]` or `dq_in[3:0]`, with the higher-numbered lane taken as the more significant bit. The result is right-aligned in a word of (length+1)×lanes bits, so in quad mode with length 1 the first nibble lands in bits [7:4].
- R5: In dual or quad mode with direction 0 (transmit), the top bits of the word go out first on the active lanes, and `dq_oe` is 0011 or 1111.
- R6: `sclk` idles low. Data is sampled on its rising edge and changes only at a falling edge. Each half period lasts divider+1 system clock cycles.
- R7: At the last falling edge of a frame the captured word moves to the receive register and receive-full (flag bit 1) is set.
- R8: If a frame ends while receive-full is already set, the receive register takes the new word and overrun (flag bit 2) is set.
- R9: Transmit-empty (flag bit 0) clears when the transmit register is written. It sets again when the engine takes the word at the start of a frame.
- R10: If a word is waiting when a frame ends, the next frame starts without a gap, so every rising-edge spacing equals one full period. If no word is waiting, `sclk` stays low until the next write.
- R11: `ss_n` is the inverse of control bit 3 and changes only when the control register is written.
- R12: Writing 1 to flag bit 1 or bit 2 clears that flag, and reading the receive register clears receive-full. Writing flag bit 0 has no effect.
- R13: `irq` is high exactly when some flag is set whose matching enable bit (same bit positions at address 5) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive-full on the receive address) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Slave select, active low |
| dq_out | output | 4 | Data lane outputs |
| dq_oe | output | 4 | Data lane output enables |
| dq_in | input | 4 | Data lane inputs |

## Verification
The hardest situation to reach from the ports is the seamless handover between frames. A second word must already be waiting when the last falling edge of the first frame arrives, and the receive register must be drained during the short window that follows. The bench polls for transmit-empty right after the first write and queues the second word while the first frame is still running. It then reads the first result before the second frame ends, and it timestamps every rising edge to confirm that the spacing stays at one period across the boundary. A bench slave model shifts one continuous word out across both frames, so that each half shows up in its own frame's result.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    parameter int DATA_W = 16;
    parameter int LEN_W  = 4;
    parameter int DIV_W  = 8;
    parameter int NLANE  = 4;
    parameter int ADDR_W = 3;
    parameter int FLAG_W = 3;

    typedef enum logic [1:0] {
        LANE_X1  = 2'd0,
        LANE_X2  = 2'd1,
        LANE_X4  = 2'd2,
        LANE_RSV = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             ss_on;
        logic             rx_dir;
        lane_mode_e       mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TXD  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_RXD  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_FLG  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd5;

    localparam int FLG_TXE = 0;
    localparam int FLG_RXF = 1;
    localparam int FLG_OVR = 2;

    function automatic int lanes_of(input lane_mode_e m);
        case (m)
            LANE_X1: return 1;
            LANE_X2: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [NLANE-1:0] lane_mask(input lane_mode_e m);
        case (m)
            LANE_X1: return 4'b0001;
            LANE_X2: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Left-justify a right-aligned frame word so its first bit sits at the top.
    function automatic logic [DATA_W-1:0] align_tx(input logic [DATA_W-1:0] w,
                                                   input logic [LEN_W-1:0]  len,
                                                   input lane_mode_e        m);
        int nbits;
        nbits = (int'(len) + 1) * lanes_of(m);
        if (nbits >= DATA_W) return w;
        return w << (DATA_W - nbits);
    endfunction

endpackage

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv
    import qspi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/qspi_regs.sv
module qspi_regs
    import qspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div_val,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_full,
    input  logic              eng_take,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] ien,
    output logic              irq
);
    logic              rx_full_q;
    logic              ovr_q;
    logic [DATA_W-1:0] rx_buf_q;

    logic wr_ctrl, wr_div, wr_txd, wr_flg, wr_ien, rd_rxd;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_div  = bus_wr && (bus_addr == ADDR_DIV);
    assign wr_txd  = bus_wr && (bus_addr == ADDR_TXD);
    assign wr_flg  = bus_wr && (bus_addr == ADDR_FLG);
    assign wr_ien  = bus_wr && (bus_addr == ADDR_IEN);
    assign rd_rxd  = bus_rd && (bus_addr == ADDR_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            div_val <= '0;
            ien     <= '0;
        end else begin
            if (wr_ctrl) ctrl    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_div)  div_val <= bus_wdata[DIV_W-1:0];
            if (wr_ien)  ien     <= bus_wdata[FLAG_W-1:0];
        end
    end

    // Transmit holding register: a write wins over a same-cycle take.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_full <= 1'b0;
            tx_word <= '0;
        end else if (wr_txd) begin
            tx_full <= 1'b1;
            tx_word <= bus_wdata;
        end else if (eng_take) begin
            tx_full <= 1'b0;
        end
    end

    // Receive side: a completing frame wins over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full_q <= 1'b0;
            ovr_q     <= 1'b0;
            rx_buf_q  <= '0;
        end else begin
            if (eng_done) begin
                rx_buf_q  <= eng_rx;
                rx_full_q <= 1'b1;
            end else if (rd_rxd || (wr_flg && bus_wdata[FLG_RXF])) begin
                rx_full_q <= 1'b0;
            end
            if (eng_done && rx_full_q)             ovr_q <= 1'b1;
            else if (wr_flg && bus_wdata[FLG_OVR]) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        flags          = '0;
        flags[FLG_TXE] = !tx_full;
        flags[FLG_RXF] = rx_full_q;
        flags[FLG_OVR] = ovr_q;
    end

    assign irq = |(flags & ien);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
            ADDR_DIV:  bus_rdata[DIV_W-1:0]  = div_val;
            ADDR_RXD:  bus_rdata             = rx_buf_q;
            ADDR_FLG:  bus_rdata[FLAG_W-1:0] = flags;
            ADDR_IEN:  bus_rdata[FLAG_W-1:0] = ien;
            default:   bus_rdata             = '0;
        endcase
    end
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
    import qspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_word,
    input  lane_mode_e        cfg_mode,
    input  logic              cfg_dir,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [NLANE-1:0]  dq_in,
    output logic              busy,
    output logic              take,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic [NLANE-1:0]  dq_out,
    output logic [NLANE-1:0]  dq_oe
);
    lane_mode_e        mode_q;
    logic              dir_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [DATA_W-1:0] txsh_q;
    logic [DATA_W-1:0] rxsh_q;
    logic              sclk_q;
    logic              busy_q;

    logic              last_clk;
    logic              fall_evt;
    logic              rise_evt;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] tx_next;

    assign last_clk = (cnt_q == '0);
    assign rise_evt = busy_q && tick && !sclk_q;
    assign fall_evt = busy_q && tick &&  sclk_q;
    assign done     = fall_evt && last_clk;
    assign take     = tx_full && (!busy_q || done);

    always_comb begin
        case (mode_q)
            LANE_X1: begin
                rx_next = {rxsh_q[DATA_W-2:0], dq_in[1]};
                tx_next = {txsh_q[DATA_W-2:0], 1'b0};
            end
            LANE_X2: begin
                rx_next = {rxsh_q[DATA_W-3:0], dq_in[1:0]};
                tx_next = {txsh_q[DATA_W-3:0], 2'b00};
            end
            default: begin
                rx_next = {rxsh_q[DATA_W-5:0], dq_in};
                tx_next = {txsh_q[DATA_W-5:0], 4'b0000};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            mode_q <= LANE_X1;
            dir_q  <= 1'b0;
            txsh_q <= '0;
            rxsh_q <= '0;
        end else begin
            if (rise_evt) begin
                sclk_q <= 1'b1;
                rxsh_q <= rx_next;
            end
            if (fall_evt) begin
                sclk_q <= 1'b0;
                if (!last_clk) begin
                    cnt_q  <= cnt_q - 1'b1;
                    txsh_q <= tx_next;
                end
            end
            if (take) begin
                busy_q <= 1'b1;
                mode_q <= cfg_mode;
                dir_q  <= cfg_dir;
                cnt_q  <= cfg_len;
                txsh_q <= align_tx(tx_word, cfg_len, cfg_mode);
                rxsh_q <= '0;
            end else if (done) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Lane drive: single lane always sends; wider modes send only when dir is 0.
    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            logic en;
            assign en        = busy_q && lane_mask(mode_q)[g] &&
                               ((mode_q == LANE_X1) || !dir_q);
            assign dq_oe[g]  = en;
            assign dq_out[g] = en && txsh_q[DATA_W - lanes_of(mode_q) + g];
        end
    endgenerate

    assign busy    = busy_q;
    assign sclk    = sclk_q;
    assign rx_word = rxsh_q;
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              ss_n,
    output logic [NLANE-1:0]  dq_out,
    output logic [NLANE-1:0]  dq_oe,
    input  logic [NLANE-1:0]  dq_in
);
    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div_val;
    logic [DATA_W-1:0] tx_word;
    logic              tx_full;
    logic              take;
    logic              done;
    logic [DATA_W-1:0] rx_word;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] ien;
    logic              busy;
    logic              tick;

    qspi_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .div_val   (div_val),
        .tx_word   (tx_word),
        .tx_full   (tx_full),
        .eng_take  (take),
        .eng_done  (done),
        .eng_rx    (rx_word),
        .flags     (flags),
        .ien       (ien),
        .irq       (irq)
    );

    qspi_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_val),
        .tick (tick)
    );

    qspi_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .tx_full  (tx_full),
        .tx_word  (tx_word),
        .cfg_mode (ctrl.mode),
        .cfg_dir  (ctrl.rx_dir),
        .cfg_len  (ctrl.len),
        .dq_in    (dq_in),
        .busy     (busy),
        .take     (take),
        .done     (done),
        .rx_word  (rx_word),
        .sclk     (sclk),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    assign ss_n = !ctrl.ss_on;
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk
    import qspi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sclk,
    input logic              ss_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NLANE-1:0]  dq_out,
    input logic [FLAG_W-1:0] flags,
    input logic              busy,
    input logic [DIV_W-1:0]  div_val
);
    logic [DIV_W:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)       hi_cnt <= '0;
        else if (sclk) hi_cnt <= hi_cnt + 1'b1;
        else           hi_cnt <= '0;
    end

    // R6: the high half of every serial clock lasts divider+1 cycles
    a_r6_high_half: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_cnt == ({1'b0, div_val} + 1'b1)));

    // R6: lane data holds while the serial clock is high
    a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(dq_out));

    // R8: overrun only rises when receive-full was already set
    a_r8_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_OVR]) |-> $past(flags[FLG_RXF]));

    // R7: the end of a frame leaves receive-full set
    a_r7_rxf_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> flags[FLG_RXF]);

    // R10: the clock is low whenever no frame is running
    a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R11: select moves only after a control write
    a_r11_ss_sw_only: assert property (@(posedge clk) disable iff (rst)
        !($past(bus_wr) && ($past(bus_addr) == ADDR_CTRL)) |-> $stable(ss_n));
endmodule

bind qspi_master qspi_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .dq_out   (dq_out),
    .flags    (flags),
    .busy     (busy),
    .div_val  (div_val)
);

// File: tb/qspi_master_bench.sv
`timescale 1ns/1ps
module qspi_master_bench;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_DIV  = 3'd1;
    localparam logic [2:0] A_TXD  = 3'd2;
    localparam logic [2:0] A_RXD  = 3'd3;
    localparam logic [2:0] A_FLG  = 3'd4;
    localparam logic [2:0] A_IEN  = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, sclk, ss_n;
    logic [3:0]  dq_out, dq_oe, dq_in;

    int checks = 0;
    int errors = 0;

    // bench slave model
    int          slv_lanes = 1;
    logic [15:0] slv_sh = '0;
    int          rise_cnt = 0;
    logic [15:0] cap = '0;
    logic [3:0]  oe_seen = '0;
    time         prev_rise = 0;
    bit          have_prev = 0;
    time         min_gap = 0;
    time         max_gap = 0;
    bit          ss_bad = 0;

    always #5 clk = ~clk;

    qspi_master u_qspi_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .ss_n(ss_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in)
    );

    assign dq_in = (slv_lanes == 1) ? {2'b00, slv_sh[15], 1'b0} :
                   (slv_lanes == 2) ? {2'b00, slv_sh[15:14]} : slv_sh[15:12];

    always @(posedge sclk) begin
        rise_cnt = rise_cnt + 1;
        oe_seen  = oe_seen | dq_oe;
        if (ss_n) ss_bad = 1;
        if (slv_lanes == 1)      cap = {cap[14:0], dq_out[0]};
        else if (slv_lanes == 2) cap = {cap[13:0], dq_out[1:0]};
        else                     cap = {cap[11:0], dq_out};
        if (have_prev) begin
            if (min_gap == 0 || ($time - prev_rise) < min_gap) min_gap = $time - prev_rise;
            if (($time - prev_rise) > max_gap) max_gap = $time - prev_rise;
        end
        prev_rise = $time;
        have_prev = 1;
    end

    always @(negedge sclk) begin
        slv_sh = slv_sh << slv_lanes;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_flag(input int bitn, output bit ok);
        logic [15:0] v;
        ok = 0;
        for (int k = 0; k < 5000; k++) begin
            rd(A_FLG, v);
            if (v[bitn]) begin ok = 1; break; end
        end
    endtask

    task automatic mon_reset(input int lanes, input logic [15:0] word, input int nbits);
        slv_lanes = lanes;
        slv_sh    = (nbits >= 16) ? word : (word << (16 - nbits));
        rise_cnt  = 0; cap = '0; oe_seen = '0;
        have_prev = 0; min_gap = 0; max_gap = 0; ss_bad = 0;
    endtask

    function automatic logic [15:0] msk(input int nbits);
        return (nbits >= 16) ? 16'hFFFF : 16'((32'd1 << nbits) - 1);
    endfunction

    task automatic run_frame(input logic [1:0] mode, input logic dir, input logic [3:0] len,
                             input logic [7:0] dv, input logic [15:0] txw,
                             input logic [15:0] slvw, input string tag);
        int lanes, nbits;
        bit ok;
        logic [15:0] v;
        logic [3:0] exp_oe;
        lanes = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : 4;
        nbits = (int'(len) + 1) * lanes;
        exp_oe = (mode == 2'd0) ? 4'b0001 : dir ? 4'b0000 : (mode == 2'd1) ? 4'b0011 : 4'b1111;
        wr(A_DIV, {8'h00, dv});
        wr(A_CTRL, {8'h00, len, 1'b1, dir, mode});
        mon_reset(lanes, slvw, nbits);
        wr(A_TXD, txw);
        wait_flag(1, ok);
        chk(ok, {tag, " R7 receive-full raised"}, 32'(ok), 1);
        chk(rise_cnt == int'(len) + 1, {tag, " R2 clock count"}, rise_cnt, int'(len) + 1);
        chk(oe_seen == exp_oe, {tag, " R3/R4/R5 lane enables"}, oe_seen, exp_oe);
        if (mode == 2'd0 || !dir)
            chk((cap & msk(nbits)) == (txw & msk(nbits)), {tag, " R3 R5 sent bits"},
                cap & msk(nbits), txw & msk(nbits));
        if (rise_cnt > 1)
            chk(min_gap == max_gap && max_gap == 20 * (int'(dv) + 1), {tag, " R6 clock period"},
                32'(max_gap), 20 * (int'(dv) + 1));
        chk(!ss_bad && !ss_n, {tag, " R11 select held"}, 32'(ss_n), 0);
        rd(A_RXD, v);
        chk(v == (slvw & msk(nbits)), {tag, " R4/R3 received word"}, v, slvw & msk(nbits));
        rd(A_FLG, v);
        chk(v == 16'h0001, {tag, " R12 read clears full"}, v, 1);
        chk(sclk == 1'b0, {tag, " R10 clock parked low"}, 32'(sclk), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired R1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] s;
        bit ok;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_FLG, v);
        chk(v == 16'h0001, "R1 flags after reset", v, 1);
        chk(sclk == 0 && ss_n == 1 && dq_oe == 0 && irq == 0, "R1 pins after reset",
            {sclk, ss_n, dq_oe, irq}, {1'b0, 1'b1, 4'b0, 1'b0});

        // R3 single-lane full-duplex sweep over divider and length
        for (int i = 0; i < 12; i++)
            run_frame(2'd0, 1'b0, 4'((i * 5 + 3) % 16), 8'(i % 4),
                      16'hA5C3 ^ 16'(i * 16'h1F31), 16'(16'h3C96 + i * 16'h0B57), "single");
        // R4 dual and quad receive
        for (int i = 0; i < 4; i++)
            run_frame(2'd1, 1'b1, 4'(i * 2 + 1), 8'(i % 2), 16'hFFFF, 16'(16'hB4E1 + i * 16'h2345), "dual-rx");
        for (int i = 0; i < 4; i++)
            run_frame(2'd2, 1'b1, 4'(i), 8'(i % 3), 16'hFFFF, 16'(16'h7A5D ^ (i * 16'h1111)), "quad-rx");
        // R4 first nibble into bits [7:4]
        run_frame(2'd2, 1'b1, 4'd1, 8'd0, 16'h0000, 16'h005A, "quad-nibble");
        // R5 dual and quad transmit
        run_frame(2'd1, 1'b0, 4'd3, 8'd1, 16'h00C6, 16'h0039, "dual-tx");
        run_frame(2'd2, 1'b0, 4'd1, 8'd0, 16'h00E7, 16'h0018, "quad-tx8");
        run_frame(2'd2, 1'b0, 4'd3, 8'd2, 16'hD2B4, 16'h4B2D, "quad-tx16");

        // R8 overrun, R12 flag clears
        wr(A_DIV, 16'h0001);
        wr(A_CTRL, {8'h00, 4'd7, 1'b1, 1'b0, 2'd0});
        mon_reset(1, 16'h0011, 8);
        wr(A_TXD, 16'h0055);
        wait_flag(1, ok);
        mon_reset(1, 16'h00C3, 8);
        wr(A_TXD, 16'h00AA);
        wait_flag(2, ok);
        chk(ok, "R8 overrun raised", 32'(ok), 1);
        rd(A_FLG, v);
        chk(v == 16'h0007, "R8 flags after overrun", v, 7);
        wr(A_FLG, 16'h0001);
        rd(A_FLG, v);
        chk(v == 16'h0007, "R12 write to empty bit ignored", v, 7);
        wr(A_FLG, 16'h0004);
        rd(A_FLG, v);
        chk(v == 16'h0003, "R12 overrun cleared", v, 3);
        rd(A_RXD, v);
        chk(v == 16'h00C3, "R8 newest word kept", v, 16'h00C3);
        rd(A_FLG, v);
        chk(v == 16'h0001, "R12 full cleared by read", v, 1);
        mon_reset(1, 16'h0000, 8);
        wr(A_TXD, 16'h0001);
        wait_flag(1, ok);
        wr(A_FLG, 16'h0002);
        rd(A_FLG, v);
        chk(v == 16'h0001, "R12 full cleared by write", v, 1);

        // R9 R10 back-to-back frames without a clock gap
        s = 16'h9E37;
        wr(A_DIV, 16'h0003);
        mon_reset(1, s, 16);
        rd(A_FLG, v);
        chk(v == 16'h0001, "R9 empty before write", v, 1);
        wr(A_TXD, 16'h00B1);
        wait_flag(0, ok);
        chk(ok, "R9 empty after take", 32'(ok), 1);
        wr(A_TXD, 16'h004E);
        rd(A_FLG, v);
        chk(v[0] == 1'b0, "R9 empty cleared by write", 32'(v[0]), 0);
        wait_flag(1, ok);
        rd(A_RXD, v);
        chk(v == {8'h00, s[15:8]}, "R10 first of pair", v, {8'h00, s[15:8]});
        wait_flag(1, ok);
        rd(A_RXD, v);
        chk(v == {8'h00, s[7:0]}, "R10 second of pair", v, {8'h00, s[7:0]});
        chk(cap == 16'hB14E, "R10 joined bits", cap, 16'hB14E);
        chk(min_gap == 80 && max_gap == 80, "R10 no gap between frames", 32'(max_gap), 80);
        rd(A_FLG, v);
        chk(v == 16'h0001, "R10 no overrun in pair", v, 1);
        repeat (50) @(negedge clk);
        chk(rise_cnt == 16 && sclk == 0, "R10 clock stopped when empty", rise_cnt, 16);

        // R13 interrupt
        wr(A_IEN, 16'h0002);
        chk(irq == 1'b0, "R13 masked empty", 32'(irq), 0);
        mon_reset(1, 16'h0000, 8);
        wr(A_TXD, 16'h0000);
        wait_flag(1, ok);
        chk(irq == 1'b1, "R13 full raises irq", 32'(irq), 1);
        rd(A_RXD, v);
        @(negedge clk);
        chk(irq == 1'b0, "R13 irq drops after read", 32'(irq), 0);
        wr(A_IEN, 16'h0001);
        chk(irq == 1'b1, "R13 empty enabled", 32'(irq), 1);
        wr(A_IEN, 16'h0000);

        // R11 select released by software only
        chk(ss_n == 1'b0, "R11 select still asserted", 32'(ss_n), 0);
        wr(A_CTRL, 16'h0070);
        chk(ss_n == 1'b1, "R11 select released", 32'(ss_n), 1);
        rd(A_CTRL, v);
        chk(v == 16'h0070, "R2 control readback", v, 16'h0070);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule